// File: doc/BRIEF.md
# Serial Control-Byte Receiver

This block is the command front end of a serially driven converter. It watches a chip-select line, a serial clock and a serial data line, all asynchronous to the system clock. It brings them into the system clock domain and detects serial-clock rising edges and chip-select falling edges. While chip select is low it samples the data line on every serial-clock rise. Zeros that arrive while the receiver is waiting are skipped. The first 1 marks the top bit of an 8-bit control word. The remaining seven bits follow MSB first.

When a word is complete, its fields are decoded and held on the outputs: input polarity, conversion clock source, two-bit operating mode and a three-bit general-purpose output port. The block pulses `start_o` as soon as a start bit is recognised, so that a sequencer can begin acquisition at once. It pulses `byte_done_o` when the word is whole. It tracks whether a conversion or calibration is running. It re-arms start-bit hunting when that operation reports completion or when chip select is toggled. A start bit that arrives while an operation is still running cancels that operation.

Top module: `ctrl_byte_rx`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, the outputs hold these values: `port_o`=000, `unipolar_o`=0 (bipolar), `int_clk_o`=1 (internal clock), `mode_o`=00, `busy_o`=0, and no pulse outputs. Start-bit hunting is armed.
- R2: While armed and with chip select low, 0 bits sampled on serial-clock rises have no effect. The first 1 is taken as the start bit, and `start_o` pulses high for exactly one system clock.
- R3: The data line is sampled only on a serial-clock rising edge while chip select is low. Serial-clock edges while chip select is high change nothing.
- R4: After the start bit, the next seven sampled bits complete the word, which is received MSB first with the start bit as bit 7. On the seventh of these, `byte_done_o` pulses for one system clock. `start_o` and `byte_done_o` are never high together.
- R5: On completion, bit 6 drives `unipolar_o` (1 = unipolar), bit 5 drives `int_clk_o` (1 = internal), and bits 4:3 drive `mode_o`. The mode codes are: 00 = short conversion, 01 = calibration, 10 = power-down, 11 = long conversion.
- R6: Bits 2:0 of the word are loaded into `port_o` as one value, in the cycle where `byte_done_o` is high. `port_o` does not change in any other cycle, and it keeps its value through power-down.
- R7: A completed word with mode 00, 01 or 11 sets `busy_o` and stops start-bit hunting. A one-cycle `op_done_i` while busy clears `busy_o` and re-arms hunting. `op_done_i` while not busy has no effect. A power-down word leaves `busy_o` clear and re-arms hunting at once.
- R8: A chip-select falling edge re-arms start-bit hunting and discards any partly received word.
- R9: A start bit recognised while `busy_o` is high also pulses `abort_o` in the same cycle as `start_o`, and clears `busy_o`.
- R10: Each serial input passes through `SYNC_STAGES` flip-flops. An input level first captured at system-clock edge n affects the outputs from edge n+`SYNC_STAGES` onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sdi_i | input | 1 | Serial data in, asynchronous |
| op_done_i | input | 1 | One-cycle pulse from the sequencer: conversion or calibration finished |
| start_o | output | 1 | One-cycle pulse: start bit recognised |
| abort_o | output | 1 | One-cycle pulse: running operation cancelled by a new start bit |
| byte_done_o | output | 1 | One-cycle pulse: control word complete and decoded |
| busy_o | output | 1 | Conversion or calibration in progress |
| unipolar_o | output | 1 | Decoded polarity, 1 = unipolar |
| int_clk_o | output | 1 | Decoded clock source, 1 = internal |
| mode_o | output | 2 | Decoded operating mode |
| port_o | output | 3 | General-purpose output port |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default 2, so the latency claim is checked at a depth that differs from the default. A wrong hard-coded delay would also show up. The serial clock runs at one sixth of the system clock. This places every serial event several system cycles apart, so that re-arming on a chip-select fall, cancelling a running operation, and ignoring edges while deselected can each be stepped through alone. It also brings completion pulses that arrive while the block is idle into reach.

// File: rtl/ctrl_byte_rx_pkg.sv
package ctrl_byte_rx_pkg;

    localparam int CTRL_W    = 8;
    localparam int PAYLOAD_W = CTRL_W - 1;
    localparam int SHIFT_W   = PAYLOAD_W - 1;
    localparam int CNT_W     = $clog2(CTRL_W);
    localparam int PORT_W    = 3;

    typedef enum logic [1:0] {
        MODE_SHORT = 2'b00,
        MODE_CAL   = 2'b01,
        MODE_PDOWN = 2'b10,
        MODE_LONG  = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic              unipolar;
        logic              int_clk;
        op_mode_e          mode;
        logic [PORT_W-1:0] port;
    } ctrl_fields_t;

    typedef struct packed {
        logic               armed;
        logic               collecting;
        logic [CNT_W-1:0]   cnt;
        logic [SHIFT_W-1:0] shreg;
        logic               busy;
        ctrl_fields_t       fields;
        logic               start;
        logic               abort;
        logic               done;
    } core_st_t;

    localparam ctrl_fields_t FIELDS_RST = '{
        unipolar: 1'b0,
        int_clk:  1'b1,
        mode:     MODE_SHORT,
        port:     '0
    };

    function automatic ctrl_fields_t decode_word(input logic [CTRL_W-1:0] w);
        ctrl_fields_t f;
        f.unipolar = w[6];
        f.int_clk  = w[5];
        f.mode     = op_mode_e'(w[4:3]);
        f.port     = w[PORT_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/ctrl_byte_rx_sync.sv
module ctrl_byte_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg_d, stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stg_d = d_i;
        end else begin : g_chain
            always_comb stg_d = {stg_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ctrl_byte_rx_front.sv
module ctrl_byte_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic cs_ni,
    input  logic sdi_i,
    output logic sclk_rise_o,
    output logic cs_fall_o,
    output logic cs_low_o,
    output logic sdi_o
);
    localparam int          N_IN    = 3;
    // index 2: chip select (idle high), 1: serial clock, 0: data
    localparam logic [N_IN-1:0] RST_VEC = 3'b100;

    logic [N_IN-1:0] raw, synced;
    assign raw = {cs_ni, sclk_i, sdi_i};

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_sync
            ctrl_byte_rx_sync #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (RST_VEC[i])
            ) u_sync (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .d_i    (raw[i]),
                .q_o    (synced[i])
            );
        end
    endgenerate

    typedef struct packed {
        logic cs;
        logic sclk;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.cs   = synced[2];
        prev_d.sclk = synced[1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '{cs: 1'b1, sclk: 1'b0};
        else         prev_q <= prev_d;
    end

    assign sclk_rise_o = synced[1] & ~prev_q.sclk;
    assign cs_fall_o   = prev_q.cs & ~synced[2];
    assign cs_low_o    = ~synced[2];
    assign sdi_o       = synced[0];
endmodule

// File: rtl/ctrl_byte_rx_core.sv
module ctrl_byte_rx_core
    import ctrl_byte_rx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_rise_i,
    input  logic              cs_fall_i,
    input  logic              cs_low_i,
    input  logic              sdi_i,
    input  logic              op_done_i,
    output logic              start_o,
    output logic              abort_o,
    output logic              byte_done_o,
    output logic              busy_o,
    output ctrl_fields_t      fields_o
);
    localparam core_st_t ST_RST = '{
        armed:      1'b1,
        collecting: 1'b0,
        cnt:        '0,
        shreg:      '0,
        busy:       1'b0,
        fields:     FIELDS_RST,
        start:      1'b0,
        abort:      1'b0,
        done:       1'b0
    };
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SHIFT_W);

    core_st_t st_d, st_q;
    ctrl_fields_t dec;

    always_comb dec = decode_word({1'b1, st_q.shreg, sdi_i});

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.abort = 1'b0;
        st_d.done  = 1'b0;

        if (cs_fall_i) begin
            st_d.armed      = 1'b1;
            st_d.collecting = 1'b0;
        end

        if (op_done_i && st_q.busy) begin
            st_d.busy  = 1'b0;
            st_d.armed = 1'b1;
        end

        if (sclk_rise_i && cs_low_i) begin
            if (st_d.collecting) begin
                if (st_d.cnt == LAST_CNT) begin
                    st_d.fields     = dec;
                    st_d.done       = 1'b1;
                    st_d.collecting = 1'b0;
                    if (dec.mode == MODE_PDOWN) begin
                        st_d.armed = 1'b1;
                    end else begin
                        st_d.busy  = 1'b1;
                        st_d.armed = 1'b0;
                    end
                end else begin
                    st_d.shreg = {st_d.shreg[SHIFT_W-2:0], sdi_i};
                    st_d.cnt   = st_d.cnt + 1'b1;
                end
            end else if (st_d.armed && sdi_i) begin
                st_d.start      = 1'b1;
                st_d.abort      = st_d.busy;
                st_d.busy       = 1'b0;
                st_d.armed      = 1'b0;
                st_d.collecting = 1'b1;
                st_d.cnt        = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_RST;
        else         st_q <= st_d;
    end

    assign start_o     = st_q.start;
    assign abort_o     = st_q.abort;
    assign byte_done_o = st_q.done;
    assign busy_o      = st_q.busy;
    assign fields_o    = st_q.fields;

    // R9
    abort_with_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> start_o);

    // R6
    port_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !byte_done_o |-> $stable(fields_o.port));

    // R7
    busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> byte_done_o);

    // R4
    pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({start_o, byte_done_o}));

    // R2
    start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);
endmodule

// File: rtl/ctrl_byte_rx.sv
module ctrl_byte_rx
    import ctrl_byte_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sclk_i,
    input  logic       cs_ni,
    input  logic       sdi_i,
    input  logic       op_done_i,
    output logic       start_o,
    output logic       abort_o,
    output logic       byte_done_o,
    output logic       busy_o,
    output logic       unipolar_o,
    output logic       int_clk_o,
    output logic [1:0] mode_o,
    output logic [2:0] port_o
);
    logic sclk_rise, cs_fall, cs_low, sdi_s;
    ctrl_fields_t fields;

    ctrl_byte_rx_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sclk_i      (sclk_i),
        .cs_ni       (cs_ni),
        .sdi_i       (sdi_i),
        .sclk_rise_o (sclk_rise),
        .cs_fall_o   (cs_fall),
        .cs_low_o    (cs_low),
        .sdi_o       (sdi_s)
    );

    ctrl_byte_rx_core u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sclk_rise_i (sclk_rise),
        .cs_fall_i   (cs_fall),
        .cs_low_i    (cs_low),
        .sdi_i       (sdi_s),
        .op_done_i   (op_done_i),
        .start_o     (start_o),
        .abort_o     (abort_o),
        .byte_done_o (byte_done_o),
        .busy_o      (busy_o),
        .fields_o    (fields)
    );

    assign unipolar_o = fields.unipolar;
    assign int_clk_o  = fields.int_clk;
    assign mode_o     = fields.mode;
    assign port_o     = fields.port;
endmodule

// File: tb/ctrl_byte_rx_bench.sv
module ctrl_byte_rx_bench;
    localparam int SYNC = 3;

    logic clk = 1'b0;
    logic rst_n, sclk, cs_n, sdi, op_done;
    logic start_o, abort_o, byte_done_o, busy_o, unipolar_o, int_clk_o;
    logic [1:0] mode_o;
    logic [2:0] port_o;

    always #4 clk = ~clk;

    ctrl_byte_rx #(.SYNC_STAGES(SYNC)) u_ctrl_byte_rx (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
        .op_done_i(op_done), .start_o(start_o), .abort_o(abort_o),
        .byte_done_o(byte_done_o), .busy_o(busy_o), .unipolar_o(unipolar_o),
        .int_clk_o(int_clk_o), .mode_o(mode_o), .port_o(port_o)
    );

    int n_cmp = 0, n_bad = 0;
    int n_start = 0, n_abort = 0, n_done = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit q_cs[$], q_sclk[$], q_sdi[$];
    bit m_armed, m_coll, m_busy, m_uni, m_int, m_start, m_abort, m_done;
    int m_cnt, m_mode, m_port;
    bit [7:0] m_word;
    bit c_cs, p_cs, c_sclk, p_sclk, c_sdi;
    int ix;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_cs.delete(); q_sclk.delete(); q_sdi.delete();
            m_armed = 1; m_coll = 0; m_busy = 0; m_uni = 0; m_int = 1;
            m_mode = 0; m_port = 0; m_cnt = 0; m_word = 0;
            m_start = 0; m_abort = 0; m_done = 0;
        end else begin
            q_cs.push_back(cs_n); q_sclk.push_back(sclk); q_sdi.push_back(sdi);
            if (q_cs.size() > SYNC + 2) begin
                void'(q_cs.pop_front()); void'(q_sclk.pop_front()); void'(q_sdi.pop_front());
            end
            ix = q_cs.size() - 1 - SYNC;
            c_cs   = (ix >= 0) ? q_cs[ix]   : 1'b1;
            c_sclk = (ix >= 0) ? q_sclk[ix] : 1'b0;
            c_sdi  = (ix >= 0) ? q_sdi[ix]  : 1'b0;
            p_cs   = (ix >= 1) ? q_cs[ix-1]   : 1'b1;
            p_sclk = (ix >= 1) ? q_sclk[ix-1] : 1'b0;
            m_start = 0; m_abort = 0; m_done = 0;
            if (p_cs && !c_cs) begin m_armed = 1; m_coll = 0; end
            if (op_done && m_busy) begin m_busy = 0; m_armed = 1; end
            if (c_sclk && !p_sclk && !c_cs) begin
                if (m_coll) begin
                    m_word = {m_word[6:0], c_sdi};
                    m_cnt++;
                    if (m_cnt == 7) begin
                        m_coll = 0; m_done = 1;
                        m_uni = m_word[6]; m_int = m_word[5];
                        m_mode = m_word[4:3]; m_port = m_word[2:0];
                        if (m_mode == 2) m_armed = 1;
                        else begin m_busy = 1; m_armed = 0; end
                    end
                end else if (m_armed && c_sdi) begin
                    m_start = 1; m_abort = m_busy; m_busy = 0;
                    m_armed = 0; m_coll = 1; m_cnt = 0; m_word = 8'h01;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2/R10 start_o", start_o, m_start);
            chk("R9 abort_o", abort_o, m_abort);
            chk("R4/R10 byte_done_o", byte_done_o, m_done);
            chk("R7 busy_o", busy_o, m_busy);
            chk("R5 unipolar_o", unipolar_o, m_uni);
            chk("R5 int_clk_o", int_clk_o, m_int);
            chk("R5 mode_o", mode_o, m_mode);
            chk("R6 port_o", port_o, m_port);
            n_start += start_o; n_abort += abort_o; n_done += byte_done_o;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send_bit(input bit b);
        sdi = b; sclk = 1'b0;
        tick(3);
        sclk = 1'b1;
        tick(3);
        sclk = 1'b0;
    endtask

    task automatic send_word(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) send_bit(w[i]);
        tick(SYNC + 3);
    endtask

    task automatic cs_toggle();
        cs_n = 1'b1; tick(SYNC + 3);
        cs_n = 1'b0; tick(SYNC + 3);
    endtask

    task automatic pulse_done();
        op_done = 1'b1; tick(1);
        op_done = 1'b0; tick(2);
    endtask

    int s0, a0, d0;

    initial begin
        rst_n = 0; cs_n = 1; sclk = 0; sdi = 0; op_done = 0;
        tick(5);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk("R1 port", port_o, 0); chk("R1 unipolar", unipolar_o, 0);
        chk("R1 int_clk", int_clk_o, 1); chk("R1 busy", busy_o, 0);
        chk("R1 mode", mode_o, 0);

        cs_n = 0; tick(SYNC + 3);
        // R2 leading zeros then power-down word 1_1_0_10_011
        send_bit(0); send_bit(0); send_bit(0);
        chk("R2 no start on zeros", n_start, 0);
        send_word(8'hD3);
        chk("R2 start count", n_start, 1); chk("R4 done count", n_done, 1);
        chk("R6 port", port_o, 3); chk("R5 mode", mode_o, 2);
        chk("R5 unipolar", unipolar_o, 1); chk("R5 int_clk", int_clk_o, 0);
        chk("R7 pdown not busy", busy_o, 0);

        // R7 rearmed at once: short conversion 1_0_1_00_110
        send_word(8'hA6);
        chk("R7 busy", busy_o, 1); chk("R6 port", port_o, 6);

        // R7 ones while busy are ignored
        s0 = n_start;
        send_bit(1); send_bit(1); send_bit(1); tick(SYNC + 3);
        chk("R7 no start while busy", n_start, s0); chk("R6 port held", port_o, 6);

        // R7 completion re-arms; calibration word 1_0_0_01_001
        pulse_done();
        chk("R7 busy cleared", busy_o, 0);
        send_word(8'h89);
        chk("R7 cal busy", busy_o, 1); chk("R6 port", port_o, 1); chk("R5 mode cal", mode_o, 1);

        // R3 edges while deselected are ignored
        s0 = n_start; cs_n = 1; tick(SYNC + 3);
        send_bit(1); send_bit(1); tick(SYNC + 3);
        chk("R3 no start cs high", n_start, s0); chk("R3 port held", port_o, 1);

        // R8/R9 reselect re-arms, start bit aborts: 1_0_0_11_111
        a0 = n_abort;
        cs_n = 0; tick(SYNC + 3);
        send_word(8'h9F);
        chk("R9 abort count", n_abort, a0 + 1); chk("R6 port", port_o, 7);
        chk("R5 mode long", mode_o, 3); chk("R7 busy", busy_o, 1);

        // R8 partial word discarded by chip-select toggle
        cs_toggle();
        d0 = n_done;
        send_bit(1); send_bit(0); send_bit(1);
        cs_toggle();
        send_word(8'hE2);
        chk("R8 one word done", n_done, d0 + 1); chk("R8 port", port_o, 2);
        chk("R8 unipolar", unipolar_o, 1); chk("R8 int_clk", int_clk_o, 1);

        // R7 completion pulse while idle is ignored
        pulse_done();
        chk("R7 cleared", busy_o, 0);
        pulse_done();
        chk("R7 idle done no effect", busy_o, 0); chk("R7 port kept", port_o, 2);

        // R1 reset mid-word
        send_bit(1); send_bit(0);
        rst_n = 0; tick(3);
        rst_n = 1; tick(1);
        chk("R1 port after reset", port_o, 0); chk("R1 int_clk after reset", int_clk_o, 1);
        chk("R1 unipolar after reset", unipolar_o, 0); chk("R1 busy after reset", busy_o, 0);
        tick(SYNC + 3);
        // R1 armed after reset
        s0 = n_start;
        send_bit(1); tick(SYNC + 3);
        chk("R1 armed after reset", n_start, s0 + 1);
        tick(60);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule